// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of external interrupt inputs and presents one interrupt request to a single processor. Each input is configured through a 32-bit register bus. Software sets whether the input is edge- or level-sensitive, which level or edge is active, its priority, the vector it reports, a mask, and a destination bit that routes it to the processor. A global task-priority threshold gates which sources may interrupt.

The processor handles a request by reading the acknowledge register. That read returns the vector of the winning source and moves the source into service. When nothing qualifies, the read returns a programmable spurious vector instead. A write to the end-of-interrupt register retires the source in service. While a source is in service, sources of equal or lower priority are held back. A source of strictly higher priority may still nest on top of it.

A global reset bit restarts the controller. It reads back as set until the internal reset has finished.

All inputs, including the raw source lines, are synchronous to `clk`. The bus is word-addressed. A read presented with `rd_en` in one cycle returns its data on `rdata` after the next rising edge.

Top module: `vpic_top`

## Requirements
- R1: After reset, `irq_o` is 0 and the registers read as follows. Every source control word reads 0x80800000, which is masked, active-high, edge-sensitive, priority 0 and vector 0. Task priority reads 15. Spurious vector reads 0xFF.
- R2: The feature word at address 0x00 holds the highest source index (NUM_SRC-1) in bits 7:0 and the highest processor index (0) in bits 15:8. All other bits read 0.
- R3: An edge-sensitive source (control bit 22 = 0) latches a request on its active edge. The request stays latched after the input returns to idle. Acknowledging that source clears the latched request.
- R4: A level-sensitive source (control bit 22 = 1) requests only while its input is at the active level. A request that is withdrawn before acknowledge leaves nothing pending.
- R5: Control bit 23 selects the active sense. The value 1 selects high / rising, and 0 selects low / falling.
- R6: A source whose mask bit (control bit 31) is 1 never drives `irq_o`. A request latched while masked is delivered once the mask is cleared.
- R7: A source is delivered only when bit 0 of its destination word (address 0x21 + 2*i) is 1.
- R8: A source is delivered only when its priority (control bits 19:16) is strictly greater than the task priority at address 0x03. A task priority of 15 therefore blocks every source.
- R9: Among qualifying sources, the highest priority wins. Equal priorities go to the lower source index.
- R10: A read of address 0x04 returns the winner's vector (control bits 7:0) and puts that source in service. With no qualifying source, the read returns the spurious vector at address 0x02.
- R11: A source in service blocks delivery of sources at the same or lower priority. A strictly higher priority source nests on top of it. Any write to address 0x05 retires the highest-priority source in service.
- R12: Control bit 30 reads 1 while the source is pending or in service. While it is 1, a write to the control word changes only the mask bit.
- R13: Writing 1 to bit 0 of address 0x01 holds the controller in reset for RST_CYCLES cycles. During that window bit 0 reads 1 and bus writes are ignored. Afterwards every register holds its R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| src_i | input | NUM_SRC | Raw source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with NUM_SRC = 4 and RST_CYCLES = 3.

Four sources are enough to mix three configurations at once: an active-high edge source, a level source and an active-low edge source. Two of these share a priority, which exercises the index tie-break. A third source sits above them, which exercises nesting.

The short reset window lets the bench count every cycle in which the reset bit reads 1. It can also drop a write inside that window and show that the write had no effect.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int VEC_W = 8;
  localparam int PRI_W = 4;

  // Word addresses of the global and processor registers
  localparam int REG_FEAT     = 0;
  localparam int REG_GCFG     = 1;
  localparam int REG_SPUR     = 2;
  localparam int REG_TPRI     = 3;
  localparam int REG_ACK      = 4;
  localparam int REG_EOI      = 5;
  localparam int REG_SRC_BASE = 32;

  // Bit positions inside a source control word
  localparam int VP_MASK    = 31;
  localparam int VP_ACT     = 30;
  localparam int VP_POL     = 23;
  localparam int VP_SENSE   = 22;
  localparam int VP_PRI_LSB = 16;

  typedef struct packed {
    logic             mask;
    logic             pol;    // 1: high / rising is active
    logic             sense;  // 1: level, 0: edge
    logic [PRI_W-1:0] pri;
    logic [VEC_W-1:0] vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RESET = '{mask: 1'b1, pol: 1'b1, sense: 1'b0,
                                     pri: '0, vec: '0};

  function automatic logic [31:0] cfg_pack(src_cfg_t c, logic act);
    logic [31:0] w;
    w = '0;
    w[VP_MASK]  = c.mask;
    w[VP_ACT]   = act;
    w[VP_POL]   = c.pol;
    w[VP_SENSE] = c.sense;
    w[VP_PRI_LSB +: PRI_W] = c.pri;
    w[VEC_W-1:0] = c.vec;
    return w;
  endfunction

  function automatic logic beats_threshold(logic [PRI_W-1:0] p,
                                           logic [PRI_W-1:0] thr);
    return p > thr;
  endfunction

  function automatic logic [PRI_W-1:0] pri_max(logic [PRI_W-1:0] a,
                                               logic [PRI_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] feature_word(int nsrc, int ncpu);
    logic [31:0] w;
    w = '0;
    w[7:0]  = 8'(nsrc - 1);
    w[15:8] = 8'(ncpu - 1);
    return w;
  endfunction

endpackage

// File: rtl/vpic_src_cell.sv
module vpic_src_cell
  import vpic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             cfg_we,
  input  src_cfg_t         cfg_wr,
  input  logic             dst_we,
  input  logic             dst_wr,
  input  logic             src_in,
  input  logic             ack_take,
  input  logic             eoi_drop,
  input  logic [PRI_W-1:0] thr,
  output src_cfg_t         cfg_o,
  output logic             dst_o,
  output logic             active_o,
  output logic             insvc_o,
  output logic             qual_o
);

  src_cfg_t cfg_q;
  logic     dst_q;
  logic     prev_in;
  logic     edge_pend;
  logic     insvc_q;
  logic     level_act;
  logic     edge_seen;
  logic     pending;

  // The edge detector works on the raw input, so a change of polarity never fakes an edge.
  assign level_act = cfg_q.pol ? src_in : ~src_in;
  assign edge_seen = cfg_q.pol ? (src_in & ~prev_in) : (~src_in & prev_in);
  assign pending   = cfg_q.sense ? level_act : edge_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      dst_q     <= 1'b0;
      prev_in   <= 1'b0;
      edge_pend <= 1'b0;
      insvc_q   <= 1'b0;
    end else if (soft_clr) begin
      cfg_q     <= CFG_RESET;
      dst_q     <= 1'b0;
      prev_in   <= 1'b0;
      edge_pend <= 1'b0;
      insvc_q   <= 1'b0;
    end else begin
      prev_in <= src_in;
      if (cfg_we) begin
        if (active_o) cfg_q.mask <= cfg_wr.mask;
        else          cfg_q      <= cfg_wr;
      end
      if (dst_we) dst_q <= dst_wr;
      if (cfg_q.sense) edge_pend <= 1'b0;
      else             edge_pend <= edge_seen | (edge_pend & ~ack_take);
      if (ack_take)      insvc_q <= 1'b1;
      else if (eoi_drop) insvc_q <= 1'b0;
    end
  end

  assign cfg_o    = cfg_q;
  assign dst_o    = dst_q;
  assign insvc_o  = insvc_q;
  assign active_o = pending | insvc_q;
  assign qual_o   = pending & ~cfg_q.mask & dst_q & ~insvc_q
                    & beats_threshold(cfg_q.pri, thr);

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int N     = 4,
  parameter int PRI_W = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]            req,
  input  logic [N-1:0][PRI_W-1:0] pri,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  logic [PRI_W-1:0] best;

  // Strict comparison keeps the lower index on a tie.
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!hit || pri[i] > best)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = pri[i];
      end
    end
  end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int RST_CYCLES = 16,
  parameter int ADDR_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(REG_FEAT);
  localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'(REG_GCFG);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(REG_SPUR);
  localparam logic [ADDR_W-1:0] A_TPRI = ADDR_W'(REG_TPRI);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(REG_ACK);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(REG_EOI);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(REG_SRC_BASE);

  // Global state
  logic [VEC_W-1:0] spur_vec;
  logic [PRI_W-1:0] task_pri;
  logic [CNT_W-1:0] busy_cnt;
  logic             busy;
  logic             wr_ok;

  // Named bus events
  logic ack_fire;
  logic eoi_fire;

  // Source decode
  logic [ADDR_W-1:0] src_off;
  logic [ADDR_W-2:0] src_idx;
  logic              src_sel;
  logic              src_is_dst;
  src_cfg_t          cfg_wr;
  logic [31:0]       unused_wbits;

  // Per-source vectors
  src_cfg_t                    cfg_arr [NUM_SRC];
  logic [NUM_SRC-1:0]          act_vec;
  logic [NUM_SRC-1:0]          insvc_vec;
  logic [NUM_SRC-1:0]          qual_vec;
  logic [NUM_SRC-1:0]          dst_vec;
  logic [NUM_SRC-1:0]          ack_take;
  logic [NUM_SRC-1:0]          eoi_drop;
  logic [NUM_SRC-1:0][PRI_W-1:0] pri_arr;

  // Arbitration results
  logic             q_hit;
  logic [IDX_W-1:0] q_idx;
  logic [VEC_W-1:0] q_vec;
  logic             is_hit;
  logic [IDX_W-1:0] is_idx;
  logic [PRI_W-1:0] is_pri;
  logic [PRI_W-1:0] thr;
  logic [31:0]      rd_word;

  assign busy     = (busy_cnt != '0);
  assign wr_ok    = wr_en & ~busy;
  assign ack_fire = rd_en & (addr == A_ACK) & ~busy;
  assign eoi_fire = wr_ok & (addr == A_EOI);

  assign src_off    = addr - A_BASE;
  assign src_idx    = src_off[ADDR_W-1:1];
  assign src_is_dst = src_off[0];
  assign src_sel    = (addr >= A_BASE) && (int'(src_off) < 2 * NUM_SRC);

  assign cfg_wr.mask  = wdata[VP_MASK];
  assign cfg_wr.pol   = wdata[VP_POL];
  assign cfg_wr.sense = wdata[VP_SENSE];
  assign cfg_wr.pri   = wdata[VP_PRI_LSB +: PRI_W];
  assign cfg_wr.vec   = wdata[VEC_W-1:0];
  assign unused_wbits = wdata;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit_here;
    assign hit_here = src_sel && (src_idx == (ADDR_W-1)'(g));
    assign ack_take[g] = ack_fire & q_hit & (q_idx == IDX_W'(g));
    assign eoi_drop[g] = eoi_fire & is_hit & (is_idx == IDX_W'(g));
    assign pri_arr[g]  = cfg_arr[g].pri;

    vpic_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (busy),
      .cfg_we   (wr_ok & hit_here & ~src_is_dst),
      .cfg_wr   (cfg_wr),
      .dst_we   (wr_ok & hit_here & src_is_dst),
      .dst_wr   (wdata[0]),
      .src_in   (src_i[g]),
      .ack_take (ack_take[g]),
      .eoi_drop (eoi_drop[g]),
      .thr      (thr),
      .cfg_o    (cfg_arr[g]),
      .dst_o    (dst_vec[g]),
      .active_o (act_vec[g]),
      .insvc_o  (insvc_vec[g]),
      .qual_o   (qual_vec[g])
    );
  end

  // Winner among deliverable sources
  vpic_arbiter #(.N(NUM_SRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_qual_arb (
    .req (qual_vec),
    .pri (pri_arr),
    .hit (q_hit),
    .idx (q_idx)
  );

  // Highest-priority source in service: the EOI target and the running level
  vpic_arbiter #(.N(NUM_SRC), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_svc_arb (
    .req (insvc_vec),
    .pri (pri_arr),
    .hit (is_hit),
    .idx (is_idx)
  );

  always_comb begin
    is_pri = '0;
    q_vec  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (is_idx == IDX_W'(i)) is_pri = pri_arr[i];
      if (q_idx == IDX_W'(i))  q_vec  = cfg_arr[i].vec;
    end
  end

  assign thr   = is_hit ? pri_max(is_pri, task_pri) : task_pri;
  assign irq_o = q_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_vec <= '1;
      task_pri <= '1;
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      spur_vec <= '1;
      task_pri <= '1;
    end else if (wr_en) begin
      if (addr == A_GCFG && wdata[0]) busy_cnt <= CNT_W'(RST_CYCLES);
      if (addr == A_SPUR) spur_vec <= wdata[VEC_W-1:0];
      if (addr == A_TPRI) task_pri <= wdata[PRI_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == A_FEAT)      rd_word = feature_word(NUM_SRC, 1);
    else if (addr == A_GCFG) rd_word = {31'b0, busy};
    else if (addr == A_SPUR) rd_word = {{(32-VEC_W){1'b0}}, spur_vec};
    else if (addr == A_TPRI) rd_word = {{(32-PRI_W){1'b0}}, task_pri};
    else if (addr == A_ACK)  rd_word = {{(32-VEC_W){1'b0}}, (q_hit ? q_vec : spur_vec)};
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel && src_idx == (ADDR_W-1)'(i)) begin
        rd_word = src_is_dst ? {31'b0, dst_vec[i]} : cfg_pack(cfg_arr[i], act_vec[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic [3:0]         task_pri,
  input logic [NUM_SRC-1:0] insvc,
  input logic               ack_fire,
  input logic               eoi_fire,
  input logic               busy
);

  // R8: the top threshold lets nothing through
  a_r8_top_threshold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (task_pri == 4'hF) |-> !irq_o);

  // R10: a successful acknowledge adds exactly one source to service
  a_r10_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && irq_o && !eoi_fire) |=> ($countones(insvc) == $past($countones(insvc)) + 1));

  // R9: an acknowledge never grants more than one source
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> $onehot0(insvc & ~$past(insvc)));

  // R11: end-of-interrupt retires exactly one source
  a_r11_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && (insvc != '0) && !ack_fire) |=> ($countones(insvc) == $past($countones(insvc)) - 1));

  // R13: inside the reset window nothing is in service and nothing is requested
  a_r13_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (insvc == '0 && !irq_o));

endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .task_pri (task_pri),
  .insvc    (insvc_vec),
  .ack_fire (ack_fire),
  .eoi_fire (eoi_fire),
  .busy     (busy)
);

// File: tb/vpic_top_tb.sv
`timescale 1ns/1ps
module vpic_top_tb;

  localparam int NS = 4;
  localparam int RC = 3;
  localparam logic [7:0] A_FEAT = 8'h00, A_GCFG = 8'h01, A_SPUR = 8'h02,
                         A_TPRI = 8'h03, A_ACK = 8'h04, A_EOI = 8'h05;
  localparam logic [31:0] ACT = 32'h4000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src_i = '0;
  logic          irq_o;

  always #2 clk = ~clk;

  vpic_top #(.NUM_SRC(NS), .RST_CYCLES(RC), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_i(src_i), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    bit          chk;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic rd_q = 1'b0;

  always @(posedge clk) rd_q <= rd_en;

  // Monitor: pops one expected item for every read the design answered
  always @(negedge clk) begin
    sb_item_t it;
    if (rd_q) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read answered with no expected item, actual=%h expected=none", rdata);
      end else begin
        it = sb_q.pop_front();
        if (it.chk) begin
          checks++;
          if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
          end
        end
      end
    end
  end

  function automatic logic [31:0] vpw(bit m, bit p, bit s, int pri, int vec);
    logic [3:0] pp;
    logic [7:0] vv;
    pp = 4'(pri);
    vv = 8'(vec);
    return {m, 1'b0, 6'b0, p, s, 2'b0, pp, 8'b0, vv};
  endfunction

  // All driver tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.chk = 1'b1; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [31:0] v);
    sb_item_t it;
    it.exp = '0; it.chk = 1'b0; it.tag = "raw";
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    src_i[i] = 1'b1;
    @(negedge clk);
    src_i[i] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq_o actual=%b expected=%b", tag, irq_o, e);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int ones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd_exp(A_FEAT, 32'h0000_0003, "R2 feature word");
    rd_exp(A_TPRI, 32'd15, "R1 task priority");
    rd_exp(A_SPUR, 32'hFF, "R1 spurious vector");
    rd_exp(8'h20, 32'h8080_0000, "R1 source 0 control");
    rd_exp(8'h21, 32'h0, "R1 source 0 destination");
    rd_exp(A_ACK, 32'hFF, "R10 ack with nothing pending");

    // Configuration
    wr(A_SPUR, 32'h3C);
    wr(8'h20, vpw(0, 1, 0, 5, 8'h10)); wr(8'h21, 1);
    wr(8'h22, vpw(0, 1, 1, 5, 8'h11)); wr(8'h23, 1);
    wr(8'h24, vpw(0, 0, 0, 9, 8'h12)); wr(8'h25, 1);
    wr(8'h26, vpw(0, 1, 0, 5, 8'h13)); wr(8'h27, 0);
    wr(A_TPRI, 0);
    chk_irq(1'b0, "R5 no request on idle inputs");

    // R3 edge latch, ack, R12 activity and write protection
    pulse(0);
    chk_irq(1'b1, "R3 edge latched after input idles");
    rd_exp(8'h20, ACT | vpw(0, 1, 0, 5, 8'h10), "R12 activity while pending");
    rd_exp(A_ACK, 32'h10, "R10 ack returns vector");
    chk_irq(1'b0, "R3 ack clears edge request");
    wr(8'h20, vpw(0, 1, 0, 7, 8'h55));
    rd_exp(8'h20, ACT | vpw(0, 1, 0, 5, 8'h10), "R12 fields locked while active");
    wr(A_EOI, 0);
    rd_exp(8'h20, vpw(0, 1, 0, 5, 8'h10), "R11 activity clear after EOI");

    // R7 destination bit
    pulse(3);
    chk_irq(1'b0, "R7 no delivery without destination");
    rd_exp(8'h26, ACT | vpw(0, 1, 0, 5, 8'h13), "R7 source 3 pending");
    wr(8'h27, 1);
    chk_irq(1'b1, "R7 delivery after destination set");
    rd_exp(A_ACK, 32'h13, "R7 ack source 3");
    wr(A_EOI, 0);

    // R4 level sense
    src_i[1] = 1'b1;
    chk_irq(1'b1, "R4 level request");
    src_i[1] = 1'b0;
    chk_irq(1'b0, "R4 level withdrawn");
    rd_exp(A_ACK, 32'h3C, "R10 spurious after withdrawn level");

    // R5 active-low edge
    src_i[2] = 1'b1;
    idle(1);
    chk_irq(1'b0, "R5 rising edge ignored on active-low source");
    src_i[2] = 1'b0;
    idle(1);
    chk_irq(1'b1, "R5 falling edge on active-low source");
    rd_exp(A_ACK, 32'h12, "R5 ack source 2");
    src_i[2] = 1'b1;
    wr(A_EOI, 0);

    // R6 mask
    wr(8'h20, vpw(1, 1, 0, 5, 8'h10));
    pulse(0);
    chk_irq(1'b0, "R6 masked source silent");
    rd_exp(8'h20, ACT | vpw(1, 1, 0, 5, 8'h10), "R6 masked request latched");
    wr(8'h20, vpw(0, 1, 0, 5, 8'h10));
    chk_irq(1'b1, "R6 delivered after unmask");
    rd_exp(A_ACK, 32'h10, "R6 ack source 0");
    wr(A_EOI, 0);

    // R8 threshold
    wr(A_TPRI, 5);
    pulse(0);
    chk_irq(1'b0, "R8 equal to task priority blocked");
    wr(A_TPRI, 4);
    chk_irq(1'b1, "R8 above task priority delivered");
    wr(A_TPRI, 15);
    chk_irq(1'b0, "R8 task priority 15 blocks all");
    wr(A_TPRI, 0);
    rd_exp(A_ACK, 32'h10, "R8 ack source 0");
    wr(A_EOI, 0);
    wr(8'h26, vpw(0, 1, 0, 0, 8'h13));
    pulse(3);
    chk_irq(1'b0, "R8 priority 0 never delivered");

    // R9 tie on priority, R11 same-level blocking
    src_i[1] = 1'b1;
    pulse(0);
    rd_exp(A_ACK, 32'h10, "R9 tie goes to lower index");
    chk_irq(1'b0, "R11 equal priority blocked while in service");
    wr(A_EOI, 0);
    chk_irq(1'b1, "R11 released after EOI");
    rd_exp(A_ACK, 32'h11, "R9 second of the tie");
    src_i[1] = 1'b0;
    wr(A_EOI, 0);

    // R9 higher priority wins, R11 lower blocked
    src_i[2] = 1'b0;
    pulse(0);
    src_i[2] = 1'b1;
    rd_exp(A_ACK, 32'h12, "R9 higher priority wins");
    chk_irq(1'b0, "R11 lower priority blocked");
    wr(A_EOI, 0);
    chk_irq(1'b1, "R11 lower delivered after EOI");
    rd_exp(A_ACK, 32'h10, "R11 ack lower source");
    wr(A_EOI, 0);

    // R11 nesting and EOI order
    pulse(0);
    rd_exp(A_ACK, 32'h10, "R11 outer ack");
    src_i[2] = 1'b0;
    idle(1);
    chk_irq(1'b1, "R11 higher priority nests");
    rd_exp(A_ACK, 32'h12, "R11 nested ack");
    src_i[2] = 1'b1;
    wr(A_EOI, 0);
    rd_exp(8'h24, vpw(0, 0, 0, 9, 8'h12), "R11 EOI retired nested source");
    rd_exp(8'h20, ACT | vpw(0, 1, 0, 5, 8'h10), "R11 outer still in service");
    wr(A_EOI, 0);
    rd_exp(8'h20, vpw(0, 1, 0, 5, 8'h10), "R11 outer retired");

    // R13 software reset
    src_i = '0;
    idle(1);
    wr(A_GCFG, 1);
    wr(A_TPRI, 2);
    ones = 0;
    for (int k = 0; k < 10; k++) begin
      rd_raw(A_GCFG, v);
      if (v[0]) ones++;
    end
    checks++;
    if (ones != RC - 1) begin
      errors++;
      $display("FAIL R13 reset bit cycles: actual=%0d expected=%0d", ones, RC - 1);
    end
    rd_exp(A_TPRI, 32'd15, "R13 write during reset ignored");
    rd_exp(A_SPUR, 32'hFF, "R13 spurious restored");
    rd_exp(8'h20, 32'h8080_0000, "R13 source control restored");
    rd_exp(8'h21, 32'h0, "R13 destination restored");
    chk_irq(1'b0, "R13 no request after reset");

    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard R10: actual=%0d left expected=0", sb_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule